// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the bookkeeping state of a set-associative first-level cache. For every line it holds a tag, a valid bit and a dirty bit. The number of sets, the number of ways, the address width and the tag width are all parameters. The data array, refill and writeback paths and bus logic sit outside it. A client presents an address with a write flag, and atomic operations drive the write flag high. One cycle later the block reports what happened to that access: a hit, a fill into a free way, a clean eviction, or an eviction of a modified line that needs writing back.

Three bulk commands act on the whole directory in a single cycle. Flush clears every modified mark and leaves lines resident. Invalidate drops every line. New-test drops every line and also clears all replacement history. The block does not accept a request in a cycle that carries a bulk command. When a set is full, a tree-shaped pseudo-LRU unit chooses the victim. It keeps one history bit per internal tree node in each set.

Top module: `cache_tag_dir`

## Requirements
- R1: After reset, no response is flagged and the block is ready, and every line is invalid, so the first access to any address reports a fill (code 01).
- R2: The address splits as tag = top TAG_W bits, set = the next log2(SETS) bits, offset = the remaining low bits. Offset bits do not affect the outcome, and equal tags in different sets are separate lines.
- R3: An accepted request (`req_valid` high while `req_ready` is high) raises `rsp_valid` on exactly the next cycle, and `rsp_valid` is low in every other cycle. A valid line with a matching tag in the indexed set reports code 00.
- R4: On a miss with at least one invalid way in the set, the lowest-numbered invalid way receives the tag, becomes valid, and takes the write flag as its dirty bit. The code is 01. A tag is never resident twice in one set.
- R5: On a miss in a full set, the way chosen by the replacement tree is replaced. The code is 11 if that way was dirty and 10 otherwise.
- R6: A write hit marks the line dirty. A read hit leaves its dirty bit unchanged.
- R7: Every hit, fill or eviction updates that set's tree. The leaf-pair node records the sibling of the accessed way, and every ancestor node points away from the accessed subtree (1 = right). The victim is found by walking from the root, going left on 0 and right on 1.
- R8: Flush clears every dirty bit in one cycle. Valid bits and tags are kept, so resident lines still hit, and a previously written line is later evicted with code 10.
- R9: Invalidate clears every valid bit in one cycle, so previously resident addresses then report code 01.
- R10: New-test clears every valid bit and resets all replacement state to zero in one cycle.
- R11: While any bulk command is high, `req_ready` is low. A request presented in that cycle is neither answered nor applied to the directory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | Access modifies the line (store or atomic) |
| req_ready | output | 1 | Request can be taken this cycle |
| cmd_flush | input | 1 | Clear all dirty bits |
| cmd_inval | input | 1 | Clear all valid bits |
| cmd_newtest | input | 1 | Clear all valid bits and replacement state |
| rsp_valid | output | 1 | Outcome strobe, one cycle after acceptance |
| rsp_code | output | 2 | 00 hit, 01 fill, 10 clean evict, 11 dirty evict |

## Verification
The assertions assume that `req_valid` and the command inputs are low while reset is asserted, so the first checked response follows a clean reset. They also assume a request with a bulk command in the same cycle is simply refused and never half-applied. The bench drives every input at the falling edge and releases requests right after the accepting edge. It deliberately presents requests together with bulk commands, so the refusal path is exercised rather than avoided. Expected codes come from walking the replacement tree by hand for fixed tag sequences in dedicated sets.

// File: rtl/cache_tag_pkg.sv
// Package: shared outcome encoding for the cache tag directory.
// Assumes: the two-bit code is decoded by the client that drives refill and writeback.
package cache_tag_pkg;

    // Access outcome; the high bit means a resident line was displaced.
    typedef enum logic [1:0] {
        OUT_HIT      = 2'b00,
        OUT_FILL     = 2'b01,
        OUT_CLEAN_EV = 2'b10,
        OUT_DIRTY_EV = 2'b11
    } outcome_e;

endpackage

// File: rtl/ctd_plru.sv
// Module: ctd_plru
// Per-set tree pseudo-LRU history. It presents the victim way of the read set
// and folds an accessed way into the history of the update set.
// Assumes: WAYS is a power of two and at least 2; SETS is a power of two.
module ctd_plru #(
    parameter int SETS = 8,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     upd_en_i,
    input  logic [$clog2(SETS)-1:0]  upd_set_i,
    input  logic [$clog2(WAYS)-1:0]  upd_way_i,
    input  logic [$clog2(SETS)-1:0]  rd_set_i,
    output logic [$clog2(WAYS)-1:0]  victim_o
);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int NODES  = WAYS - 1;
    localparam int LEVELS = WAY_W;
    localparam int BOTTOM = (WAYS - 1) / 2;

    logic [NODES-1:0] tree_q [SETS];
    logic [NODES-1:0] rd_row;
    logic             any_bit;

    // Fold an access to 'way' into one set's tree row.
    function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] row,
                                               input logic [WAY_W-1:0] way);
        int idx;
        int par;
        touch = row;
        idx = int'(way >> 1) + BOTTOM;
        touch[WAY_W'(idx)] = ~way[0];
        for (int lvl = 1; lvl < LEVELS; lvl++) begin
            par = (idx - 1) / 2;
            touch[WAY_W'(par)] = idx[0];
            idx = par;
        end
    endfunction

    // Walk the read set's tree from the root to a leaf pair to find the victim.
    always_comb begin
        int idx;
        rd_row = tree_q[rd_set_i];
        idx = 0;
        for (int lvl = 0; lvl < LEVELS - 1; lvl++) begin
            idx = rd_row[WAY_W'(idx)] ? (2 * idx + 2) : (2 * idx + 1);
        end
        victim_o = WAY_W'((idx - BOTTOM) * 2 + int'(rd_row[WAY_W'(idx)]));
    end

    // History storage: cleared by reset or new-test, updated on each access.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (upd_en_i) begin
            tree_q[upd_set_i] <= touch(tree_q[upd_set_i], upd_way_i);
        end
    end

    // Reduction of all history bits, used by the clear check.
    always_comb begin
        any_bit = 1'b0;
        for (int s = 0; s < SETS; s++) any_bit = any_bit | (|tree_q[s]);
    end

    // R10
    plru_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !any_bit);

endmodule

// File: rtl/ctd_store.sv
// Module: ctd_store
// Flop-based tag, valid and dirty arrays with a read port for one set,
// one line write per cycle and single-cycle bulk clears.
// Assumes: the top never writes a line in a cycle that carries a bulk clear.
module ctd_store #(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush_i,
    input  logic                     inval_i,
    input  logic                     wr_en_i,
    input  logic                     wr_fill_i,
    input  logic                     wr_write_i,
    input  logic [$clog2(SETS)-1:0]  wr_set_i,
    input  logic [$clog2(WAYS)-1:0]  wr_way_i,
    input  logic [TAG_W-1:0]         wr_tag_i,
    input  logic [$clog2(SETS)-1:0]  rd_set_i,
    output logic [TAG_W-1:0]         rd_tag_o [WAYS],
    output logic [WAYS-1:0]          rd_valid_o,
    output logic [WAYS-1:0]          rd_dirty_o
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic             any_valid;
    logic             any_dirty;

    // Read port: present every way of the indexed set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) rd_tag_o[w] = tag_q[rd_set_i][w];
        rd_valid_o = valid_q[rd_set_i];
        rd_dirty_o = dirty_q[rd_set_i];
    end

    // Tag array: written only when a line is filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
        end else if (wr_en_i && wr_fill_i) begin
            tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
        end
    end

    // Valid bits: cleared in bulk by invalidate, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (inval_i) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (wr_en_i && wr_fill_i) begin
            valid_q[wr_set_i][wr_way_i] <= 1'b1;
        end
    end

    // Dirty bits: cleared in bulk by flush, loaded on fill, or-ed on hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) dirty_q[s] <= '0;
        end else if (flush_i) begin
            for (int s = 0; s < SETS; s++) dirty_q[s] <= '0;
        end else if (wr_en_i) begin
            if (wr_fill_i) dirty_q[wr_set_i][wr_way_i] <= wr_write_i;
            else           dirty_q[wr_set_i][wr_way_i] <= dirty_q[wr_set_i][wr_way_i] | wr_write_i;
        end
    end

    // Whole-array reductions, used by the bulk-clear checks.
    always_comb begin
        any_valid = 1'b0;
        any_dirty = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            any_valid = any_valid | (|valid_q[s]);
            any_dirty = any_dirty | (|dirty_q[s]);
        end
    end

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !any_dirty);

    // R9
    inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_i |=> !any_valid);

endmodule

// File: rtl/ctd_lookup.sv
// Module: ctd_lookup
// Combinational classification of one access against the ways of its set:
// tag match, lowest free way, chosen way and outcome code.
// Assumes: at most one way of a set holds a given valid tag.
module ctd_lookup
    import cache_tag_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20
) (
    input  logic [TAG_W-1:0]         req_tag_i,
    input  logic [TAG_W-1:0]         way_tag_i [WAYS],
    input  logic [WAYS-1:0]          way_valid_i,
    input  logic [WAYS-1:0]          way_dirty_i,
    input  logic [$clog2(WAYS)-1:0]  victim_i,
    output logic [WAYS-1:0]          hit_vec_o,
    output logic                     hit_o,
    output logic [$clog2(WAYS)-1:0]  sel_way_o,
    output outcome_e                 outcome_o
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] free_way;
    logic             has_free;

    // Per-way tag compare qualified by valid.
    always_comb begin
        for (int w = 0; w < WAYS; w++)
            hit_vec_o[w] = way_valid_i[w] && (way_tag_i[w] == req_tag_i);
    end

    // Encode the hitting way and the lowest-numbered invalid way.
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        has_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec_o[w]) hit_way = WAY_W'(w);
            if (!way_valid_i[w]) begin
                free_way = WAY_W'(w);
                has_free = 1'b1;
            end
        end
    end

    // Pick the way to touch and the outcome: hit, then free way, then victim.
    always_comb begin
        hit_o = |hit_vec_o;
        if (hit_o) begin
            sel_way_o = hit_way;
            outcome_o = OUT_HIT;
        end else if (has_free) begin
            sel_way_o = free_way;
            outcome_o = OUT_FILL;
        end else begin
            sel_way_o = victim_i;
            outcome_o = way_dirty_i[victim_i] ? OUT_DIRTY_EV : OUT_CLEAN_EV;
        end
    end

endmodule

// File: rtl/cache_tag_dir.sv
// Module: cache_tag_dir
// Tag directory for a set-associative cache. Splits the address, classifies
// the access, updates tag/valid/dirty and replacement state, and registers a
// two-bit outcome one cycle later. Bulk flush, invalidate and new-test
// commands take one cycle and refuse any request presented with them.
// Assumes: SETS and WAYS are powers of two, both at least 2;
// ADDR_W > TAG_W + log2(SETS).
module cache_tag_dir
    import cache_tag_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              req_ready,
    input  logic              cmd_flush,
    input  logic              cmd_inval,
    input  logic              cmd_newtest,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int OFF_W = ADDR_W - TAG_W - SET_W;

    logic [TAG_W-1:0] req_tag;
    logic [SET_W-1:0] req_set;
    logic             unused_offset_bits;
    logic             cmd_any;
    logic             acc;
    logic [TAG_W-1:0] set_tags [WAYS];
    logic [WAYS-1:0]  set_valid;
    logic [WAYS-1:0]  set_dirty;
    logic [WAY_W-1:0] victim;
    logic [WAYS-1:0]  hit_vec;
    logic             hit;
    logic [WAY_W-1:0] sel_way;
    outcome_e         outcome;

    // Address fields: tag on top, set in the middle, offset ignored.
    assign req_tag            = req_addr[ADDR_W-1 -: TAG_W];
    assign req_set            = req_addr[OFF_W +: SET_W];
    assign unused_offset_bits = ^req_addr[OFF_W-1:0];

    // Bulk commands take the cycle; requests wait.
    assign cmd_any   = cmd_flush | cmd_inval | cmd_newtest;
    assign req_ready = ~cmd_any;
    assign acc       = req_valid & req_ready;

    ctd_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (cmd_flush),
        .inval_i    (cmd_inval | cmd_newtest),
        .wr_en_i    (acc),
        .wr_fill_i  (~hit),
        .wr_write_i (req_write),
        .wr_set_i   (req_set),
        .wr_way_i   (sel_way),
        .wr_tag_i   (req_tag),
        .rd_set_i   (req_set),
        .rd_tag_o   (set_tags),
        .rd_valid_o (set_valid),
        .rd_dirty_o (set_dirty)
    );

    ctd_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (cmd_newtest),
        .upd_en_i  (acc),
        .upd_set_i (req_set),
        .upd_way_i (sel_way),
        .rd_set_i  (req_set),
        .victim_o  (victim)
    );

    ctd_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .req_tag_i   (req_tag),
        .way_tag_i   (set_tags),
        .way_valid_i (set_valid),
        .way_dirty_i (set_dirty),
        .victim_i    (victim),
        .hit_vec_o   (hit_vec),
        .hit_o       (hit),
        .sel_way_o   (sel_way),
        .outcome_o   (outcome)
    );

    // Response register: strobe and code one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= OUT_HIT;
        end else begin
            rsp_valid <= acc;
            if (acc) rsp_code <= outcome;
        end
    end

    // R3
    accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R3
    rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_flush || cmd_inval || cmd_newtest) |=> !rsp_valid);

    // R4
    unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(hit_vec));

endmodule

// File: tb/tb_cache_tag_dir.sv
// Bench: directed scenarios against the default 8-set, 4-way, 32/20-bit directory.
module tb_cache_tag_dir;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_write;
    logic        req_ready;
    logic        cmd_flush;
    logic        cmd_inval;
    logic        cmd_newtest;
    logic        rsp_valid;
    logic [1:0]  rsp_code;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    localparam logic [1:0] C_HIT = 2'b00, C_FILL = 2'b01, C_CLEAN = 2'b10, C_DIRTY = 2'b11;

    always #2 clk = ~clk;

    cache_tag_dir dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_ready(req_ready), .cmd_flush(cmd_flush),
        .cmd_inval(cmd_inval), .cmd_newtest(cmd_newtest), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code)
    );

    function automatic logic [31:0] mk(input logic [19:0] tg, input logic [2:0] st,
                                       input logic [8:0] off);
        return {tg, st, off};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // One access; expects strobe plus code on the edge after acceptance.
    task automatic access(input logic [19:0] tg, input logic [2:0] st, input logic [8:0] off,
                          input logic wr, input logic [1:0] expc, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = mk(tg, st, off); req_write = wr;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        check(rsp_valid && rsp_code == expc, req, {rsp_valid, rsp_code}, {1'b1, expc});
    endtask

    // One bulk command with a competing write request that must be refused.
    task automatic bulk(input logic f, input logic i, input logic n,
                        input logic [19:0] tg, input logic [2:0] st, input string req);
        @(negedge clk);
        cmd_flush = f; cmd_inval = i; cmd_newtest = n;
        req_valid = 1'b1; req_addr = mk(tg, st, 9'h0); req_write = 1'b1;
        #1;
        check(req_ready == 1'b0, {req, " R11 ready"}, int'(req_ready), 0);
        @(posedge clk); #1;
        cmd_flush = 1'b0; cmd_inval = 1'b0; cmd_newtest = 1'b0;
        req_valid = 1'b0; req_write = 1'b0;
        check(rsp_valid == 1'b0, {req, " R11 no response"}, int'(rsp_valid), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        cmd_flush = 1'b0; cmd_inval = 1'b0; cmd_newtest = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_basic();
        access(20'h11, 3'd2, 9'h000, 1'b0, C_FILL, "R1 first access fills");
        access(20'h11, 3'd2, 9'h1FF, 1'b0, C_HIT,  "R2 R3 other offset hits");
        @(posedge clk); #1;
        check(rsp_valid == 1'b0, "R3 strobe only after accept", int'(rsp_valid), 0);
        access(20'h11, 3'd3, 9'h000, 1'b0, C_FILL, "R2 same tag other set");
        access(20'h12, 3'd2, 9'h000, 1'b0, C_FILL, "R2 other tag same set");
    endtask

    // Set 5, reads only: fills, then tree-driven victims.
    task automatic t_plru();
        access(20'hA, 3'd5, 9'h0, 1'b0, C_FILL,  "R4 fill way0");
        access(20'hB, 3'd5, 9'h0, 1'b0, C_FILL,  "R4 fill way1");
        access(20'hC, 3'd5, 9'h0, 1'b0, C_FILL,  "R4 fill way2");
        access(20'hD, 3'd5, 9'h0, 1'b0, C_FILL,  "R4 fill way3");
        access(20'hE, 3'd5, 9'h0, 1'b0, C_CLEAN, "R5 R7 evict way0");
        access(20'hB, 3'd5, 9'h0, 1'b0, C_HIT,   "R7 way1 kept");
        access(20'hF, 3'd5, 9'h0, 1'b0, C_CLEAN, "R7 evict way2");
        access(20'hD, 3'd5, 9'h0, 1'b0, C_HIT,   "R7 way3 kept");
        access(20'hC, 3'd5, 9'h0, 1'b0, C_CLEAN, "R7 evicted tag misses");
    endtask

    // Set 6: write fill and write hit produce dirty victims.
    task automatic t_dirty();
        access(20'hA, 3'd6, 9'h0, 1'b1, C_FILL,  "R4 write fill");
        access(20'hB, 3'd6, 9'h0, 1'b0, C_FILL,  "R4 read fill");
        access(20'hC, 3'd6, 9'h0, 1'b0, C_FILL,  "R4 read fill");
        access(20'hD, 3'd6, 9'h0, 1'b0, C_FILL,  "R4 read fill");
        access(20'hB, 3'd6, 9'h0, 1'b1, C_HIT,   "R6 write hit");
        access(20'hE, 3'd6, 9'h0, 1'b0, C_CLEAN, "R5 clean victim way2");
        access(20'hF, 3'd6, 9'h0, 1'b0, C_DIRTY, "R5 dirty victim from write fill");
        access(20'h10, 3'd6, 9'h0, 1'b0, C_CLEAN, "R5 clean victim way3");
        access(20'h13, 3'd6, 9'h0, 1'b0, C_DIRTY, "R6 write hit made line dirty");
    endtask

    // Set 7: a read hit must keep a written line dirty.
    task automatic t_read_hit();
        access(20'hA, 3'd7, 9'h0, 1'b1, C_FILL,  "R6 write fill");
        access(20'hA, 3'd7, 9'h4, 1'b0, C_HIT,   "R6 read hit");
        access(20'hB, 3'd7, 9'h0, 1'b0, C_FILL,  "R4 fill");
        access(20'hC, 3'd7, 9'h0, 1'b0, C_FILL,  "R4 fill");
        access(20'hD, 3'd7, 9'h0, 1'b0, C_FILL,  "R4 fill");
        access(20'hE, 3'd7, 9'h0, 1'b0, C_DIRTY, "R6 read hit kept dirty");
    endtask

    // Set 1: flush keeps lines but drops dirty; refused write in set 4.
    task automatic t_flush();
        access(20'hA, 3'd1, 9'h0, 1'b1, C_FILL, "R4 write fill");
        access(20'hB, 3'd1, 9'h0, 1'b1, C_FILL, "R4 write fill");
        access(20'hC, 3'd1, 9'h0, 1'b1, C_FILL, "R4 write fill");
        access(20'hD, 3'd1, 9'h0, 1'b1, C_FILL, "R4 write fill");
        bulk(1'b1, 1'b0, 1'b0, 20'h777, 3'd4, "R8 flush");
        access(20'hA, 3'd1, 9'h0, 1'b0, C_HIT,   "R8 line kept after flush");
        access(20'hE, 3'd1, 9'h0, 1'b0, C_CLEAN, "R8 written line now clean");
        access(20'h777, 3'd4, 9'h0, 1'b0, C_FILL, "R11 refused request not applied");
    endtask

    task automatic t_inval();
        bulk(1'b0, 1'b1, 1'b0, 20'h888, 3'd4, "R9 invalidate");
        access(20'hA, 3'd1, 9'h0, 1'b0, C_FILL, "R9 line dropped");
        access(20'h11, 3'd2, 9'h0, 1'b0, C_FILL, "R9 other set dropped");
    endtask

    task automatic t_newtest();
        access(20'h55, 3'd0, 9'h0, 1'b1, C_FILL, "R10 write fill");
        access(20'h55, 3'd0, 9'h0, 1'b0, C_HIT,  "R10 resident");
        bulk(1'b0, 1'b0, 1'b1, 20'h999, 3'd0, "R10 new-test");
        access(20'h55, 3'd0, 9'h0, 1'b0, C_FILL,  "R10 line dropped");
        access(20'h56, 3'd0, 9'h0, 1'b0, C_FILL,  "R10 fill");
        access(20'h57, 3'd0, 9'h0, 1'b0, C_FILL,  "R10 fill");
        access(20'h58, 3'd0, 9'h0, 1'b0, C_FILL,  "R10 fill");
        access(20'h59, 3'd0, 9'h0, 1'b0, C_CLEAN, "R10 fresh order victim way0");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_plru();
        t_dirty();
        t_read_hit();
        t_flush();
        t_inval();
        t_newtest();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule